// File: doc/BRIEF.md
# Parity Counter Wire Test Generator

This block drives two groups of wires under test and checks what comes back at their far ends. One group carries an N-bit count that goes upward with a parity bit that keeps the group's total number of ones even. The other group carries an N-bit count that goes downward with a parity bit that keeps its total odd. Each group therefore drives N+1 wires, and the parity bit travels over a wire under test like every other bit.

The two counters start as bitwise complements and step in opposite directions, so they stay complements. A count wire in one group always carries the opposite value of the count wire at the same position in the other group. A short between the groups, or a switch that is stuck closed, then corrupts at least one group's parity.

A pulse on `start_i` begins a run of 2^N cycles. During the run, a parity checker for each group examines every received word against that group's convention. Any mismatch sets a fail flag for that group, and the flag stays set until reset. When the run ends, `done_o` rises and the counters are back at their starting values.

Top module: `wire_parity_tester`

## Requirements
- R1: After reset, `up_tx_o` is all zeros, the count bits of `dn_tx_o` are all ones with its parity bit making the total odd, and `done_o`, `up_fail_o` and `dn_fail_o` are 0.
- R2: `up_tx_o[N-1:0]` holds the up count and `up_tx_o[N]` is the even-parity bit, so `up_tx_o` always has an even number of ones.
- R3: `dn_tx_o[N-1:0]` holds the down count and `dn_tx_o[N]` is the odd-parity bit, so `dn_tx_o` always has an odd number of ones.
- R4: In the k-th cycle of a run (k counted from 0), the up count reads k and the down count reads all-ones minus k. The count fields of the two words are therefore bitwise complements in every cycle.
- R5: A `start_i` pulse while idle or done starts a run that lasts exactly 2^N cycles. After it, `done_o` is 1 and stays 1 until the next start, and both words are back at their reset values.
- R6: A `start_i` pulse during a run has no effect: the pattern sequence continues and `done_o` rises at the original time.
- R7: During a run, a received up word with odd parity sets `up_fail_o`, and a received down word with even parity sets `dn_fail_o`. A stuck wire, or a wired-AND bridge between same-position bits of the two groups, raises the flag of each group whose word it corrupts.
- R8: Received words are not checked outside a run, so faulty inputs while idle or done leave the fail flags at 0.
- R9: Once set, a fail flag stays 1 through later fault-free runs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a test run |
| up_rx_i | input | N+1 | Far end of the up-count wire group |
| dn_rx_i | input | N+1 | Far end of the down-count wire group |
| up_tx_o | output | N+1 | Driven up-count word: {even parity, count} |
| dn_tx_o | output | N+1 | Driven down-count word: {odd parity, count} |
| done_o | output | 1 | Run complete; held until the next start |
| up_fail_o | output | 1 | Sticky parity failure on the up group |
| dn_fail_o | output | 1 | Sticky parity failure on the down group |

## Verification
Four properties are checked on every cycle: the parity of each driven word, the complement relation between the two count fields, the single step per run cycle, and the hold behaviour of `done_o` and of the fail flags. Only the bench scenarios can show the following: the exact run length, that a start pulse in mid-run is ignored, that faults on idle inputs are ignored, and that a stuck wire or a bridge between groups actually raises the expected fail flag. In those scenarios, the expected wire words are queued per cycle and compared as the design produces them.

// File: rtl/wptst_pkg.sv
`timescale 1ns/1ps
package wptst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wptst_rst_sync.sv
`timescale 1ns/1ps
// Asserts reset at once and releases it on the clock.
module wptst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wptst_seq.sv
`timescale 1ns/1ps
// Run sequencer: idle -> run for 2^CNT_W cycles -> done.
module wptst_seq
  import wptst_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic run_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST_CYC = {CNT_W{1'b1}};

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             cyc_en;

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    cyc_en  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cyc_d   = '0;
          cyc_en  = 1'b1;
        end
      end
      ST_RUN: begin
        cyc_en = 1'b1;
        if (cyc_q == LAST_CYC) begin
          state_d = ST_DONE;
          cyc_d   = '0;
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cyc_en) cyc_q <= cyc_d;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/wptst_gen.sv
`timescale 1ns/1ps
// Pattern generator: N-bit counter plus a parity bit on top.
module wptst_gen #(
  parameter int CNT_W    = 4,
  parameter bit COUNT_UP = 1'b1,
  parameter bit ODD_PAR  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W:0]   tx_o
);
  localparam logic [CNT_W-1:0] INIT_VAL = COUNT_UP ? {CNT_W{1'b0}} : {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (COUNT_UP) begin : g_up
      always_comb cnt_d = cnt_q + 1'b1;
    end else begin : g_down
      always_comb cnt_d = cnt_q - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_VAL;
    else if (step_i) cnt_q <= cnt_d;
  end

  assign tx_o = {(^cnt_q) ^ ODD_PAR, cnt_q};
endmodule

// File: rtl/wptst_chk.sv
`timescale 1ns/1ps
// Far-end parity checker with sticky failure flag.
module wptst_chk #(
  parameter int WORD_W  = 5,
  parameter bit ODD_PAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [WORD_W-1:0] rx_i,
  output logic              fail_o
);
  logic fail_q, fail_d, bad;

  always_comb begin
    bad    = en_i && ((^rx_i) != ODD_PAR);
    fail_d = fail_q | bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/wire_parity_tester.sv
`timescale 1ns/1ps
module wire_parity_tester #(
  parameter int CNT_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [CNT_W:0] up_rx_i,
  input  logic [CNT_W:0] dn_rx_i,
  output logic [CNT_W:0] up_tx_o,
  output logic [CNT_W:0] dn_tx_o,
  output logic           done_o,
  output logic           up_fail_o,
  output logic           dn_fail_o
);
  localparam int WORD_W = CNT_W + 1;

  logic rst_n_int;
  logic run;

  wptst_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  wptst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .start_i(start_i),
    .run_o(run), .done_o(done_o)
  );

  wptst_gen #(.CNT_W(CNT_W), .COUNT_UP(1'b1), .ODD_PAR(1'b0)) u_gen_up (
    .clk(clk), .rst_n(rst_n_int), .step_i(run), .tx_o(up_tx_o)
  );

  wptst_gen #(.CNT_W(CNT_W), .COUNT_UP(1'b0), .ODD_PAR(1'b1)) u_gen_dn (
    .clk(clk), .rst_n(rst_n_int), .step_i(run), .tx_o(dn_tx_o)
  );

  wptst_chk #(.WORD_W(WORD_W), .ODD_PAR(1'b0)) u_chk_up (
    .clk(clk), .rst_n(rst_n_int), .en_i(run), .rx_i(up_rx_i), .fail_o(up_fail_o)
  );

  wptst_chk #(.WORD_W(WORD_W), .ODD_PAR(1'b1)) u_chk_dn (
    .clk(clk), .rst_n(rst_n_int), .en_i(run), .rx_i(dn_rx_i), .fail_o(dn_fail_o)
  );
endmodule

// File: rtl/wire_parity_tester_sva.sv
`timescale 1ns/1ps
module wire_parity_tester_sva #(
  parameter int CNT_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           run,
  input logic [CNT_W:0] up_tx_o,
  input logic [CNT_W:0] dn_tx_o,
  input logic           done_o,
  input logic           up_fail_o,
  input logic           dn_fail_o
);
  // R2
  up_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (^up_tx_o) == 1'b0);

  // R3
  dn_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (^dn_tx_o) == 1'b1);

  // R4
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_tx_o[CNT_W-1:0] == ~dn_tx_o[CNT_W-1:0]);

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> up_tx_o[CNT_W-1:0] == CNT_W'($past(up_tx_o[CNT_W-1:0]) + 1'b1));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R9
  up_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_fail_o |=> up_fail_o);

  // R9
  dn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fail_o |=> dn_fail_o);
endmodule

bind wire_parity_tester wire_parity_tester_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .run(run),
  .up_tx_o(up_tx_o), .dn_tx_o(dn_tx_o), .done_o(done_o),
  .up_fail_o(up_fail_o), .dn_fail_o(dn_fail_o)
);

// File: tb/sim_wire_parity_tester.sv
`timescale 1ns/1ps
module sim_wire_parity_tester;
  localparam int N   = 4;
  localparam int W   = N + 1;
  localparam int CYC = 1 << N;

  typedef struct packed {
    logic [W-1:0] up;
    logic [W-1:0] dn;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] up_tx, dn_tx, up_rx, dn_rx;
  logic done, up_fail, dn_fail;

  logic [W-1:0] up_stk_en = '0, up_stk_val = '0, dn_stk_en = '0, dn_stk_val = '0;
  logic         bridge_en = 1'b0;
  int           bridge_bit = 0;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  wire_parity_tester #(.CNT_W(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .up_rx_i(up_rx), .dn_rx_i(dn_rx),
    .up_tx_o(up_tx), .dn_tx_o(dn_tx),
    .done_o(done), .up_fail_o(up_fail), .dn_fail_o(dn_fail)
  );

  // Wire channel with injected stuck-at and wired-AND bridge faults
  always_comb begin
    logic [W-1:0] u, d;
    logic         wand_v;
    u = (up_tx & ~up_stk_en) | (up_stk_val & up_stk_en);
    d = (dn_tx & ~dn_stk_en) | (dn_stk_val & dn_stk_en);
    if (bridge_en) begin
      wand_v = u[bridge_bit] & d[bridge_bit];
      u[bridge_bit] = wand_v;
      d[bridge_bit] = wand_v;
    end
    up_rx = u;
    dn_rx = d;
  end

  function automatic logic [W-1:0] exp_up(input int k);
    logic [N-1:0] c;
    c = N'(k);
    return {^c, c};
  endfunction

  function automatic logic [W-1:0] exp_dn(input int k);
    logic [N-1:0] c;
    c = N'(CYC - 1 - k);
    return {~(^c), c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per run cycle
  always @(negedge clk) begin
    if (mon_on && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(up_tx == e.up, "R2/R4 up word", 32'(up_tx), 32'(e.up));
      check(dn_tx == e.dn, "R3/R4 dn word", 32'(dn_tx), 32'(e.dn));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Driver: queues expected words, pulses start, optionally re-pulses mid-run
  task automatic run_test(input int glitch_at);
    for (int k = 0; k < CYC; k++) sb_q.push_back('{up: exp_up(k), dn: exp_dn(k)});
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    mon_on = 1'b1;
    if (glitch_at >= 0) begin
      repeat (glitch_at) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
    check(done == 1'b1, "R5 done after 2^N cycles", 32'(done), 32'd1);
    check(up_tx == exp_up(0), "R5 up word back at start", 32'(up_tx), 32'(exp_up(0)));
    check(dn_tx == exp_dn(0), "R5 dn word back at start", 32'(dn_tx), 32'(exp_dn(0)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(up_tx == '0, "R1 up word", 32'(up_tx), 32'd0);
    check(dn_tx == {1'b1, {N{1'b1}}} , "R1 dn word", 32'(dn_tx), 32'h1f);
    check(done == 1'b0, "R1 done", 32'(done), 32'd0);
    check(up_fail == 1'b0 && dn_fail == 1'b0, "R1 fail flags", 32'({up_fail, dn_fail}), 32'd0);

    // Clean run
    run_test(-1);
    check(up_fail == 1'b0 && dn_fail == 1'b0, "R7 clean run no fail", 32'({up_fail, dn_fail}), 32'd0);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R5 done held", 32'(done), 32'd1);

    // R6 start in mid-run ignored
    run_test(5);
    check(up_fail == 1'b0 && dn_fail == 1'b0, "R6 no fail", 32'({up_fail, dn_fail}), 32'd0);

    // R8 faulty inputs while done: no check
    up_stk_en = 5'b00001; up_stk_val = 5'b00001;
    repeat (4) @(negedge clk);
    check(up_fail == 1'b0, "R8 idle fault ignored", 32'(up_fail), 32'd0);

    // R7 stuck-at-1 on up bit 0
    run_test(-1);
    check(up_fail == 1'b1, "R7 stuck wire up fail", 32'(up_fail), 32'd1);
    check(dn_fail == 1'b0, "R7 stuck wire dn clean", 32'(dn_fail), 32'd0);

    // R9 sticky through a clean run
    up_stk_en = '0; up_stk_val = '0;
    run_test(-1);
    check(up_fail == 1'b1, "R9 up fail sticky", 32'(up_fail), 32'd1);

    // R7 bridge between same-position bits of the groups
    do_reset();
    check(up_fail == 1'b0 && dn_fail == 1'b0, "R9 cleared by reset", 32'({up_fail, dn_fail}), 32'd0);
    bridge_en = 1'b1; bridge_bit = 2;
    run_test(-1);
    check(up_fail == 1'b1, "R7 bridge up fail", 32'(up_fail), 32'd1);
    check(dn_fail == 1'b1, "R7 bridge dn fail", 32'(dn_fail), 32'd1);
    bridge_en = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule